// File: doc/BRIEF.md
# Bit Test and Reset Unit

This block carries out one bit-test-and-reset operation per start pulse. It picks one bit out of a bit string by an offset, reports the old value of that bit on a carry output, and leaves the bit cleared. The offset comes either from a 32-bit register operand or from an 8-bit immediate.

The bit string can be a 16-bit or 32-bit register value, or it can live in byte-wide memory. For a register value, the offset wraps within the operand width. The cleared value is returned on `result` when `done` pulses. For memory, the base is the address of the byte that holds bit 0 of the string, and a signed offset can reach bytes on either side of it. The unit reads that byte over a request/acknowledge port, writes it back with the selected bit cleared, and then pulses `done`.

Top module: `btr_unit`

## Requirements
- R1: When `done` is high, `carry` equals the value the selected bit had before the operation.
- R2: In register mode, `result` equals the operand with the selected bit cleared. Every other bit, including bits 31..16 in 16-bit mode, is copied unchanged.
- R3: In register mode the offset (register or zero-extended immediate) is taken modulo 16 when `half_size`=1 and modulo 32 when `half_size`=0.
- R4: In memory mode with a register offset, the byte address is `mem_base` plus the offset arithmetically shifted right by 3 (two's complement, so negative offsets address lower bytes). The bit within that byte is offset[2:0].
- R5: In memory mode with an immediate offset, only imm[4:0] is used, zero-extended, so the reach is bytes 0..3 above the base.
- R6: A memory operation issues exactly one read (`mem_req`=1, `mem_we`=0), held with a stable address until `mem_ack`. It then issues exactly one write to the same address, with the read byte's selected bit cleared, held until `mem_ack`. Only after that does `done` go high.
- R7: `done` lasts one cycle. `busy` is high from the cycle after an accepted start up to and including the `done` cycle. A start while `busy` is ignored.
- R8: A register-mode operation raises `done` in the second cycle after the clock edge that samples `start`.
- R9: After reset, `busy`, `done`, `carry`, `mem_req`, `mem_we` and `result` are all 0.
- R10: `carry` changes only in a `done` cycle, and a memory operation leaves `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation (taken only when idle) |
| mem_mode | input | 1 | 1: bit string in memory; 0: register operand |
| use_imm | input | 1 | 1: offset from `imm_off`; 0: from `reg_off` |
| half_size | input | 1 | Register mode: 1 selects a 16-bit operand |
| reg_val | input | 32 | Register operand |
| reg_off | input | 32 | Register offset (signed in memory mode) |
| imm_off | input | 8 | Immediate offset |
| mem_base | input | 32 | Byte address holding bit 0 of the string |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Old value of the selected bit |
| result | output | 32 | Register-mode cleared operand |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Request acknowledge |

## Verification
Register operations use random operands with offsets far beyond the operand width. This separates proper modulo wrapping from truncation errors in 16-bit and 32-bit mode, and operands whose selected bit is already zero show whether `carry` follows the bit or stays stuck. Memory operations mix positive and negative register offsets, including -1 and the most negative value, which separates an arithmetic shift from a logical one. They also use immediates with bits 7..5 set, which shows whether the 5-bit mask is applied. The acknowledge latency varies between 0 and 2 cycles, and extra start pulses arrive mid-operation, which exercises request holding and start blocking.

// File: rtl/btr_pkg.sv
package btr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REG  = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_FIN  = 3'd4
  } btr_state_e;

  typedef struct packed {
    logic mem_mode;
    logic use_imm;
    logic half_size;
  } btr_ctl_t;
endpackage

// File: rtl/btr_reg_path.sv
module btr_reg_path #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int OFF_W  = 32,
  parameter int IMM_W  = 8
) (
  input  logic              half_size,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] value,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [IMM_W-1:0]  imm_off,
  output logic [DATA_W-1:0] cleared,
  output logic              old_bit
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int HIDX_W = $clog2(HALF_W);

  logic [OFF_W-1:0] off_sel;
  logic [IDX_W-1:0] idx;
  logic             unused_hi;

  assign off_sel   = use_imm ? OFF_W'(imm_off) : reg_off;
  assign unused_hi = ^off_sel[OFF_W-1:IDX_W];

  // wrap inside the operand width
  always_comb begin
    if (half_size) idx = IDX_W'(off_sel[HIDX_W-1:0]);
    else           idx = off_sel[IDX_W-1:0];
  end

  assign old_bit = value[idx];

  for (genvar i = 0; i < DATA_W; i++) begin : g_clr
    assign cleared[i] = value[i] & (idx != IDX_W'(i));
  end
endmodule

// File: rtl/btr_addr_gen.sv
module btr_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 32,
  parameter int IMM_W      = 8,
  parameter int IMM_MASK_W = 5,
  parameter int BIT_W      = 3
) (
  input  logic              use_imm,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [IMM_W-1:0]  imm_off,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [BIT_W-1:0]  bit_idx
);
  logic [OFF_W-1:0]        eff_off;
  logic signed [OFF_W-1:0] disp;
  logic                    unused_imm;

  assign unused_imm = ^imm_off[IMM_W-1:IMM_MASK_W];
  assign eff_off    = use_imm ? OFF_W'(imm_off[IMM_MASK_W-1:0]) : reg_off;
  assign disp       = $signed(eff_off) >>> BIT_W;
  assign byte_addr  = base + ADDR_W'(disp);
  assign bit_idx    = eff_off[BIT_W-1:0];
endmodule

// File: rtl/btr_seq.sv
module btr_seq
  import btr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mem_mode,
  input  logic       mem_ack,
  output btr_state_e state,
  output logic       accept,
  output logic       busy,
  output logic       done
);
  btr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = mem_mode ? ST_RD : ST_REG;
      ST_REG:  state_d = ST_FIN;
      ST_RD:   if (mem_ack) state_d = ST_WR;
      ST_WR:   if (mem_ack) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state  = state_q;
  assign accept = start && (state_q == ST_IDLE);
  assign busy   = (state_q != ST_IDLE);
  assign done   = (state_q == ST_FIN);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/btr_unit.sv
module btr_unit
  import btr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int HALF_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 32,
  parameter int IMM_W      = 8,
  parameter int IMM_MASK_W = 5,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mem_mode,
  input  logic              use_imm,
  input  logic              half_size,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [ADDR_W-1:0] mem_base,
  output logic              busy,
  output logic              done,
  output logic              carry,
  output logic [DATA_W-1:0] result,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int BIT_W = $clog2(BYTE_W);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  btr_state_e state;
  logic       accept;

  btr_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (start),
    .mem_mode (mem_mode),
    .mem_ack  (mem_ack),
    .state    (state),
    .accept   (accept),
    .busy     (busy),
    .done     (done)
  );

  // operand capture
  btr_ctl_t          ctl_q;
  logic [DATA_W-1:0] val_q;
  logic [OFF_W-1:0]  off_q;
  logic [IMM_W-1:0]  imm_q;
  logic [ADDR_W-1:0] base_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctl_q  <= '0;
      val_q  <= '0;
      off_q  <= '0;
      imm_q  <= '0;
      base_q <= '0;
    end else if (accept) begin
      ctl_q  <= '{mem_mode: mem_mode, use_imm: use_imm, half_size: half_size};
      val_q  <= reg_val;
      off_q  <= reg_off;
      imm_q  <= imm_off;
      base_q <= mem_base;
    end
  end

  logic [DATA_W-1:0] reg_cleared;
  logic              reg_old;
  btr_reg_path #(.DATA_W(DATA_W), .HALF_W(HALF_W), .OFF_W(OFF_W), .IMM_W(IMM_W)) u_reg (
    .half_size (ctl_q.half_size),
    .use_imm   (ctl_q.use_imm),
    .value     (val_q),
    .reg_off   (off_q),
    .imm_off   (imm_q),
    .cleared   (reg_cleared),
    .old_bit   (reg_old)
  );

  logic [ADDR_W-1:0] byte_addr;
  logic [BIT_W-1:0]  bit_idx;
  btr_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IMM_W(IMM_W),
                 .IMM_MASK_W(IMM_MASK_W), .BIT_W(BIT_W)) u_addr (
    .use_imm   (ctl_q.use_imm),
    .base      (base_q),
    .reg_off   (off_q),
    .imm_off   (imm_q),
    .byte_addr (byte_addr),
    .bit_idx   (bit_idx)
  );

  // data path next-state
  logic              byte_en, cf_en, res_en;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              cf_q, cf_d;
  logic [DATA_W-1:0] res_q, res_d;

  always_comb begin
    byte_en = (state == ST_RD) && mem_ack;
    byte_d  = mem_rdata;
    res_en  = (state == ST_REG);
    res_d   = reg_cleared;
    cf_en   = (state == ST_REG) || ((state == ST_WR) && mem_ack);
    cf_d    = (state == ST_REG) ? reg_old : byte_q[bit_idx];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      byte_q <= '0;
      cf_q   <= 1'b0;
      res_q  <= '0;
    end else begin
      if (byte_en) byte_q <= byte_d;
      if (cf_en)   cf_q   <= cf_d;
      if (res_en)  res_q  <= res_d;
    end
  end

  assign carry     = cf_q;
  assign result    = res_q;
  assign mem_req   = (state == ST_RD) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = byte_addr;
  assign mem_wdata = byte_q & ~(BYTE_W'(1) << bit_idx);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R6
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(mem_we) |-> $past(mem_ack));
  // R2
  reg_clear_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && !ctl_q.mem_mode) |-> ((res_q & ~val_q) == '0)
      && ($countones(val_q ^ res_q) == 32'(carry)));
  // R10
  cf_only_at_done_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$stable(cf_q) |-> done);
  // R10
  res_mem_keep_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_req |=> $stable(res_q));
endmodule

// File: tb/sim_btr_unit.sv
module sim_btr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mem_mode = 1'b0, use_imm = 1'b0, half_size = 1'b0;
  logic [31:0] reg_val = '0, reg_off = '0, mem_base = '0;
  logic [7:0]  imm_off = '0;
  logic        busy, done, carry, mem_req, mem_we;
  logic [31:0] result, mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  btr_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_mode(mem_mode), .use_imm(use_imm),
    .half_size(half_size), .reg_val(reg_val), .reg_off(reg_off), .imm_off(imm_off),
    .mem_base(mem_base), .busy(busy), .done(done), .carry(carry), .result(result),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // memory model: 256 bytes, random ack latency 0..2
  logic [7:0]  mem_img [256];
  int          wait_cnt = 0;
  int          tot_rd = 0, tot_wr = 0, tot_done = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [7:0]  last_wr_data = '0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (done) tot_done <= tot_done + 1;
    if (mem_req && !mem_ack) begin
      if (wait_cnt == 0) begin
        mem_ack  <= 1'b1;
        wait_cnt <= int'($urandom % 3);
        if (mem_we) begin
          mem_img[mem_addr[7:0]] <= mem_wdata;
          last_wr_addr <= mem_addr;
          last_wr_data <= mem_wdata;
          tot_wr <= tot_wr + 1;
        end else begin
          mem_rdata    <= mem_img[mem_addr[7:0]];
          last_rd_addr <= mem_addr;
          tot_rd <= tot_rd + 1;
        end
      end else begin
        wait_cnt <= wait_cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int f_idx(logic ui, logic hs, logic [31:0] ro, logic [7:0] io);
    logic [31:0] o = ui ? {24'd0, io} : ro;
    return hs ? int'(o[3:0]) : int'(o[4:0]);
  endfunction

  function automatic logic [31:0] f_addr(logic ui, logic [31:0] ro, logic [7:0] io, logic [31:0] b);
    logic [31:0] o = ui ? {27'd0, io[4:0]} : ro;
    return b + {{3{o[31]}}, o[31:3]};
  endfunction

  function automatic int f_bit(logic ui, logic [31:0] ro, logic [7:0] io);
    return ui ? int'(io[2:0]) : int'(ro[2:0]);
  endfunction

  task automatic do_op(input logic mm, input logic ui, input logic hs, input logic [31:0] v,
                       input logic [31:0] ro, input logic [7:0] io, input logic [31:0] ba,
                       input bit poke);
    int          n;
    int          rd0, wr0, dn0, idx, bi;
    logic [31:0] res0, ea, er;
    logic [7:0]  ob, eb;
    logic        ec;
    res0 = result; rd0 = tot_rd; wr0 = tot_wr; dn0 = tot_done;
    ea = f_addr(ui, ro, io, ba);
    bi = f_bit(ui, ro, io);
    ob = mem_img[ea[7:0]];
    @(negedge clk);
    mem_mode = mm; use_imm = ui; half_size = hs; reg_val = v; reg_off = ro;
    imm_off = io; mem_base = ba; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 60) begin
      if (poke && n == 2) begin
        start = 1'b1; reg_val = ~v; reg_off = ro + 32'd9; imm_off = io + 8'd3; mem_base = ba + 32'd5;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(done, "R7 done reached", 32'(done), 32'd1);
    if (!mm) begin
      idx = f_idx(ui, hs, ro, io);
      er  = v & ~(32'd1 << idx);
      ec  = v[idx];
      chk(n == 2, "R8 register latency", 32'(n), 32'd2);
      chk(carry == ec, "R1 carry register", 32'(carry), 32'(ec));
      chk(result == er, hs ? "R3 R2 result 16-bit" : "R3 R2 result 32-bit", result, er);
    end else begin
      eb = ob & ~(8'd1 << bi);
      ec = ob[bi];
      chk(carry == ec, "R1 carry memory", 32'(carry), 32'(ec));
      chk(tot_rd - rd0 == 1 && tot_wr - wr0 == 1, "R6 one read one write",
          32'((tot_rd - rd0) * 16 + (tot_wr - wr0)), 32'h11);
      chk(last_rd_addr == ea, ui ? "R5 read address" : "R4 read address", last_rd_addr, ea);
      chk(last_wr_addr == ea, "R6 write address", last_wr_addr, ea);
      chk(last_wr_data == eb, "R6 write data", 32'(last_wr_data), 32'(eb));
      chk(result == res0, "R10 result kept", result, res0);
    end
    @(negedge clk);
    chk(!done && !busy, "R7 done one cycle", {30'd0, done, busy}, 32'd0);
    chk(tot_done - dn0 == 1, "R7 single done", 32'(tot_done - dn0), 32'd1);
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(!busy && tot_done - dn0 == 1, "R7 start while busy ignored",
          32'(tot_done - dn0), 32'd1);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem_img[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9
    chk({busy, done, carry, mem_req, mem_we} == 5'd0, "R9 reset outputs",
        {27'd0, busy, done, carry, mem_req, mem_we}, 32'd0);
    chk(result == 32'd0, "R9 reset result", result, 32'd0);

    // directed corners
    do_op(0, 0, 0, 32'h8000_0000, 32'd31,         8'd0,  '0, 0);
    do_op(0, 0, 1, 32'hFFFF_FFFF, 32'd16,         8'd0,  '0, 0);
    do_op(0, 0, 1, 32'h0000_7FFF, 32'hFFFF_FFFF,  8'd0,  '0, 0);
    do_op(0, 1, 0, 32'h0000_0020, 32'd0,          8'h25, '0, 0);
    do_op(0, 1, 1, 32'h0001_0000, 32'd0,          8'hF0, '0, 0);
    do_op(1, 0, 0, 32'd0, 32'hFFFF_FFFF, 8'd0, 32'h0000_1040, 0);
    do_op(1, 0, 0, 32'd0, 32'h8000_0000, 8'd0, 32'h1000_0080, 0);
    do_op(1, 1, 0, 32'd0, 32'd0,         8'hFF, 32'h0000_2010, 0);
    do_op(1, 1, 0, 32'd0, 32'd0,         8'hE3, 32'h0000_2010, 0);
    do_op(1, 0, 0, 32'd0, 32'd13,        8'd0,  32'h0000_3000, 1);
    do_op(0, 0, 0, 32'h1234_5678, 32'd77, 8'd0, '0, 1);

    // random mix
    for (int k = 0; k < 120; k++) begin
      logic [31:0] ro;
      ro = $urandom;
      if (k % 3 == 0) ro = 32'($signed(ro) >>> 20);
      do_op(1'($urandom), 1'($urandom), 1'($urandom), $urandom, ro, 8'($urandom),
            $urandom, (k % 17) == 5);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule